// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block derives the bit timing of a CAN node from the system clock. A programmable prescaler turns the clock into time quanta. Once per quantum, a small state machine steps through the parts of a bit: a one-quantum synchronization slot, a first timing segment that covers propagation and the first phase, and a second phase segment. When the first timing segment ends, the receive line is sampled. The sampled bit goes to the bit stream logic together with a one-cycle strobe and a code that reports how the bit was synchronized.

The bit stream logic answers with the next bit to transmit in the same cycle as the strobe, so there is no processing delay. That bit is driven on the transmit output when the next bit starts. The receive line is looked at once per quantum. A falling (recessive-to-dominant) transition between two quanta is an edge. While the bit stream logic reports the bus idle, an edge restarts the bit (hard synchronization). During a frame, an edge moves the bit boundary by the phase error, capped at the jump width. At most one such adjustment is made between two sample points.

All segment fields are programmed as their length minus one. The bit length in quanta is therefore the two segment fields plus three.

Top module: `can_bit_timer`

## Requirements
- R1: One quantum lasts cfgPresc+1 clocks. With no edges on rxIn, consecutive sample strobes are (cfgSeg1+cfgSeg2+3)*(cfgPresc+1) clocks apart.
- R2: Quanta in a bit are numbered from 0, and quantum 0 is the sync slot. The sample point is the end of quantum cfgSeg1+1 plus any lengthening. samplePoint is high for exactly one cycle, in the cycle after that quantum ends.
- R3: sampledBit takes the value rxIn had in the clock that ends the sampling quantum, and holds it until the next sample point.
- R4: txOut changes only when a new bit starts. It then takes the nextBit value that was present while samplePoint was high. If samplePoint is high in that same cycle, the current nextBit is used.
- R5: An edge seen while busIdle is 1 is a hard synchronization: the quantum that holds the edge becomes the sync slot of a new bit.
- R6: During a frame (busIdle 0), an edge in quantum p of the first segment (1 ≤ p ≤ sample quantum) lengthens that segment by min(p, cfgJump+1) quanta.
- R7: During a frame, an edge in quantum p of the second segment has phase error e = last quantum + 1 − p. If e ≤ cfgJump+1, quantum p becomes the sync slot of a new bit. Otherwise the second segment is shortened by cfgJump+1 quanta.
- R8: After one synchronization of either kind, further edges have no effect until the next sample point. During a frame, an edge in the sync slot causes no adjustment.
- R9: At each sample point syncMode reports the synchronization performed since the previous sample point: 0 none, 1 hard, 2 resynchronization. It changes only while samplePoint is high.
- R10: While rstN is low: txOut=1, samplePoint=0, sampledBit=1, syncMode=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgPresc | input | PRESC_W | Quantum length minus one, in clocks |
| cfgSeg1 | input | SEG1_W | First timing segment length minus one, in quanta |
| cfgSeg2 | input | SEG2_W | Second phase segment length minus one, in quanta |
| cfgJump | input | JUMP_W | Jump width minus one, in quanta |
| busIdle | input | 1 | From bit stream logic: 1 selects hard synchronization |
| rxIn | input | 1 | Receive line (1 recessive) |
| nextBit | input | 1 | Next bit to transmit, valid while samplePoint is high |
| samplePoint | output | 1 | One-cycle strobe after each sample point |
| sampledBit | output | 1 | Bus value taken at the last sample point |
| syncMode | output | 2 | Synchronization kind since the previous sample point |
| txOut | output | 1 | Transmit line |

## Verification
The bench targets an edge that falls on the sampling quantum itself. A design that treats this as second-segment timing would sample on the edge instead of lengthening. It checks phase errors just under, equal to and over the jump width. An off-by-one there would either start the new bit one quantum off or shorten by the wrong amount. A prescaler of zero puts the sample strobe and the next bit start in adjacent clocks. A design that latches nextBit one cycle late would transmit a stale bit. Dense noise on the receive line checks the one-synchronization lock. A missing lock would shift the bit boundary several times per bit and misplace later sample strobes.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  typedef enum logic [1:0] {
    SYNC_NONE   = 2'd0,
    SYNC_HARD   = 2'd1,
    SYNC_RESYNC = 2'd2
  } sync_kind_e;

  // strobes from the timing control to the bit datapath
  typedef struct packed {
    logic       tick;       // a quantum ends in this clock
    logic       sampleNow;  // this quantum is the sampling quantum
    logic       bitStart;   // a new bit begins after this quantum
    sync_kind_e syncKind;   // sync performed since last sample point
  } cbt_strobe_t;

endpackage

// File: rtl/cbt_ctrl.sv
module cbt_ctrl
  import cbt_pkg::*;
#(
  parameter int PRESC_W = 10,
  parameter int SEG1_W  = 4,
  parameter int SEG2_W  = 3,
  parameter int JUMP_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PRESC_W-1:0] cfgPresc,
  input  logic [SEG1_W-1:0]  cfgSeg1,
  input  logic [SEG2_W-1:0]  cfgSeg2,
  input  logic [JUMP_W-1:0]  cfgJump,
  input  logic               busIdle,
  input  logic               fallEdge,
  output cbt_strobe_t        strobes
);

  localparam int MAX_POS = (1 << SEG1_W) + (1 << SEG2_W) + (1 << JUMP_W) + 2;
  localparam int POS_W   = $clog2(MAX_POS + 1);
  typedef logic [POS_W-1:0] pos_t;

  logic [PRESC_W-1:0] prescCnt;
  logic               tick;
  pos_t               posR, posN, extR, extN, cutR, cutN;
  pos_t               seg1F, seg2F, jumpF, seg1End, bitEnd, earlyErr;
  pos_t               seg1EndAdj, bitEndAdj;
  logic               lockR, lockN;
  sync_kind_e         accR, accN;
  logic               edgeQ, hardEv, resyncEv, sampleNow, bitStart;

  // quantum generation
  assign tick = (prescCnt == cfgPresc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prescCnt <= '0;
    else       prescCnt <= tick ? '0 : prescCnt + 1'b1;
  end

  // functional lengths and current segment ends
  assign seg1F    = pos_t'(cfgSeg1) + pos_t'(1);
  assign seg2F    = pos_t'(cfgSeg2) + pos_t'(1);
  assign jumpF    = pos_t'(cfgJump) + pos_t'(1);
  assign seg1End  = seg1F + extR;
  assign bitEnd   = seg1End + seg2F - cutR;
  assign earlyErr = bitEnd + pos_t'(1) - posR;

  assign edgeQ    = tick & fallEdge & ~lockR;
  assign hardEv   = edgeQ & busIdle;
  assign resyncEv = edgeQ & ~busIdle & (posR != '0);

  always_comb begin
    posN       = posR;
    extN       = extR;
    cutN       = cutR;
    lockN      = lockR;
    accN       = accR;
    sampleNow  = 1'b0;
    bitStart   = 1'b0;
    seg1EndAdj = seg1End;
    bitEndAdj  = bitEnd;
    if (tick) begin
      posN = posR + pos_t'(1);
      if (hardEv) begin
        posN     = pos_t'(1);
        extN     = '0;
        cutN     = '0;
        bitStart = 1'b1;
        lockN    = 1'b1;
        accN     = SYNC_HARD;
      end else begin
        if (resyncEv) begin
          lockN = 1'b1;
          accN  = SYNC_RESYNC;
          if (posR <= seg1End) begin
            extN = extR + ((posR < jumpF) ? posR : jumpF);
          end else if (earlyErr <= jumpF) begin
            posN     = pos_t'(1);
            extN     = '0;
            cutN     = '0;
            bitStart = 1'b1;
          end else begin
            cutN = cutR + jumpF;
          end
        end
        if (!bitStart) begin
          seg1EndAdj = seg1F + extN;
          bitEndAdj  = seg1EndAdj + seg2F - cutN;
          sampleNow  = (posR == seg1EndAdj);
          if (posR == bitEndAdj) begin
            posN     = '0;
            extN     = '0;
            cutN     = '0;
            bitStart = 1'b1;
          end
        end
      end
      if (sampleNow) begin
        lockN = 1'b0;
        accN  = SYNC_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posR  <= '0;
      extR  <= '0;
      cutR  <= '0;
      lockR <= 1'b0;
      accR  <= SYNC_NONE;
    end else begin
      posR  <= posN;
      extR  <= extN;
      cutR  <= cutN;
      lockR <= lockN;
      accR  <= accN;
    end
  end

  assign strobes = '{tick: tick, sampleNow: sampleNow, bitStart: bitStart, syncKind: accR};

  // R6
  ext_within_jump_chk: assert property (@(posedge clk) disable iff (!rstN)
    extR <= jumpF);

  // R7
  cut_within_jump_chk: assert property (@(posedge clk) disable iff (!rstN)
    cutR <= jumpF);

  // R8
  single_lengthen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (extR > $past(extR)) |-> !$past(lockR));

endmodule

// File: rtl/cbt_dp.sv
module cbt_dp
  import cbt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  cbt_strobe_t strobes,
  input  logic        rxIn,
  input  logic        nextBit,
  output logic        fallEdge,
  output logic        samplePoint,
  output logic        sampledBit,
  output sync_kind_e  syncMode,
  output logic        txOut
);

  logic prevRx;
  logic pendBit;

  // line value at the end of the previous quantum
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             prevRx <= 1'b1;
    else if (strobes.tick) prevRx <= rxIn;
  end

  assign fallEdge = prevRx & ~rxIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      samplePoint <= 1'b0;
      sampledBit  <= 1'b1;
      syncMode    <= SYNC_NONE;
      pendBit     <= 1'b1;
      txOut       <= 1'b1;
    end else begin
      samplePoint <= strobes.sampleNow;
      if (strobes.sampleNow) begin
        sampledBit <= rxIn;
        syncMode   <= strobes.syncKind;
      end
      if (samplePoint) pendBit <= nextBit;
      if (strobes.bitStart) txOut <= samplePoint ? nextBit : pendBit;
    end
  end

  // R2
  strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    samplePoint |=> !samplePoint);

  // R4
  tx_only_at_bit_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txOut) |-> $past(strobes.bitStart));

  // R9
  mode_only_at_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(syncMode) |-> samplePoint);

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import cbt_pkg::*;
#(
  parameter int PRESC_W = 10,
  parameter int SEG1_W  = 4,
  parameter int SEG2_W  = 3,
  parameter int JUMP_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PRESC_W-1:0] cfgPresc,
  input  logic [SEG1_W-1:0]  cfgSeg1,
  input  logic [SEG2_W-1:0]  cfgSeg2,
  input  logic [JUMP_W-1:0]  cfgJump,
  input  logic               busIdle,
  input  logic               rxIn,
  input  logic               nextBit,
  output logic               samplePoint,
  output logic               sampledBit,
  output logic [1:0]         syncMode,
  output logic               txOut
);

  cbt_strobe_t strobes;
  logic        fallEdge;
  sync_kind_e  modeQ;

  cbt_ctrl #(
    .PRESC_W(PRESC_W),
    .SEG1_W (SEG1_W),
    .SEG2_W (SEG2_W),
    .JUMP_W (JUMP_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .cfgPresc(cfgPresc),
    .cfgSeg1 (cfgSeg1),
    .cfgSeg2 (cfgSeg2),
    .cfgJump (cfgJump),
    .busIdle (busIdle),
    .fallEdge(fallEdge),
    .strobes (strobes)
  );

  cbt_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .rxIn       (rxIn),
    .nextBit    (nextBit),
    .fallEdge   (fallEdge),
    .samplePoint(samplePoint),
    .sampledBit (sampledBit),
    .syncMode   (modeQ),
    .txOut      (txOut)
  );

  assign syncMode = modeQ;

endmodule

// File: tb/can_bit_timer_tb_top.sv
module can_bit_timer_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] presc = '0;
  logic [3:0] s1 = '0;
  logic [2:0] s2 = '0;
  logic [1:0] jw = '0;
  logic       idle = 1'b1;
  logic       rx = 1'b1;
  logic       nb = 1'b1;
  logic       samplePoint, sampledBit, txOut;
  logic [1:0] syncMode;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  can_bit_timer dut_i (
    .clk(clk), .rstN(rstN), .cfgPresc(presc), .cfgSeg1(s1), .cfgSeg2(s2),
    .cfgJump(jw), .busIdle(idle), .rxIn(rx), .nextBit(nb),
    .samplePoint(samplePoint), .sampledBit(sampledBit),
    .syncMode(syncMode), .txOut(txOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int mPc, mPos, mExt, mCut, mSm, mAcc;
  bit mLock, mPrevRx, mPend, mTx, mSp, mSb;
  int covLong = 0, covShort = 0, covCutStart = 0, covIgnored = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPc = 0; mPos = 0; mExt = 0; mCut = 0; mSm = 0; mAcc = 0;
      mLock = 0; mPrevRx = 1; mPend = 1; mTx = 1; mSp = 0; mSb = 1;
    end else begin
      automatic bit tk = (mPc == int'(presc));
      automatic bit spOld = mSp;
      automatic bit smp = 0;
      automatic bit startB = 0;
      mPc = tk ? 0 : mPc + 1;
      mSp = 0;
      if (tk) begin
        automatic int sj = int'(jw) + 1;
        automatic int l1 = int'(s1) + 1 + mExt;
        automatic int bl = l1 + int'(s2) + 1 - mCut;
        automatic bit fall = mPrevRx && !rx;
        if (fall && mLock) covIgnored++;
        if (fall && !mLock && idle) begin
          mPos = 1; mExt = 0; mCut = 0; startB = 1; mLock = 1; mAcc = 1;
        end else begin
          if (fall && !mLock && mPos != 0) begin
            mLock = 1; mAcc = 2;
            if (mPos <= l1) begin
              mExt += (mPos < sj) ? mPos : sj; covLong++;
            end else if (bl + 1 - mPos <= sj) begin
              mPos = 1; mExt = 0; mCut = 0; startB = 1; covCutStart++;
            end else begin
              mCut += sj; covShort++;
            end
          end
          if (!startB) begin
            l1 = int'(s1) + 1 + mExt;
            bl = l1 + int'(s2) + 1 - mCut;
            if (mPos == l1) smp = 1;
            if (mPos == bl) begin
              mPos = 0; mExt = 0; mCut = 0; startB = 1;
            end else mPos++;
          end
        end
        if (smp) begin
          mSp = 1; mSb = rx; mSm = mAcc; mAcc = 0; mLock = 0;
        end
        mPrevRx = rx;
        if (startB) mTx = spOld ? nb : mPend;
      end
      if (spOld) mPend = nb;
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      // R2 R5 R6 R7 R8: sample strobe position
      check(samplePoint == mSp, "R2/R6/R7/R8", "samplePoint", samplePoint, mSp);
      // R3
      check(sampledBit == mSb, "R3", "sampledBit", sampledBit, mSb);
      // R9
      check(int'(syncMode) == mSm, "R9", "syncMode", syncMode, mSm);
      // R4
      check(txOut == mTx, "R4", "txOut", txOut, mTx);
    end
  end

  always @(negedge clk) nb = 1'($urandom_range(0, 1));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic doReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    // R10
    check(txOut == 1, "R10", "txOut in reset", txOut, 1);
    check(samplePoint == 0, "R10", "samplePoint in reset", samplePoint, 0);
    check(sampledBit == 1, "R10", "sampledBit in reset", sampledBit, 1);
    check(syncMode == 0, "R10", "syncMode in reset", syncMode, 0);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic setCfg(input int p, input int a, input int b, input int j);
    presc = 10'(p); s1 = 4'(a); s2 = 3'(b); jw = 2'(j);
  endtask

  task automatic sendFrame(input int nBits, input int cpb);
    idle = 1; rx = 1;
    repeat (40) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      rx = (i == 0) ? 1'b0 : 1'($urandom_range(0, 1));
      for (int c = 0; c < cpb; c++) begin
        @(negedge clk);
        if (i == 0 && c == cpb / 2) idle = 0;
      end
    end
    rx = 1; idle = 1;
    repeat (3 * cpb) @(negedge clk);
  endtask

  initial begin
    int t0, t1;
    bit spSeen[5];
    bit sbAt, smOk;
    @(negedge clk);

    // R1: idle bus, bit spacing = (4+2+3)*(2+1) = 27 clocks
    setCfg(2, 4, 2, 1); idle = 1; rx = 1;
    doReset();
    t0 = -1; t1 = -1;
    for (int n = 0; n < 200 && t1 < 0; n++) begin
      @(negedge clk);
      if (samplePoint) begin
        if (t0 < 0) t0 = cyc; else t1 = cyc;
      end
    end
    check(t1 - t0 == 27, "R1", "sample spacing", t1 - t0, 27);

    // R5: hard sync, tick every clock, sample at quantum 4 after the edge quantum
    setCfg(0, 3, 1, 0); idle = 1; rx = 1;
    doReset();
    repeat (10) @(negedge clk);
    rx = 0;
    sbAt = 1; smOk = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      spSeen[k] = samplePoint;
      if (k == 4) begin
        sbAt = sampledBit;
        smOk = (syncMode == 2'd1);
      end
    end
    for (int k = 0; k < 4; k++)
      check(spSeen[k] == 0, "R5", "no strobe before sample quantum", spSeen[k], 0);
    check(spSeen[4] == 1, "R5", "strobe after hard sync", spSeen[4], 1);
    check(sbAt == 0, "R3", "sampled dominant after hard sync", sbAt, 0);
    check(smOk, "R9", "syncMode reports hard (1)", smOk, 1);
    rx = 1;
    repeat (20) @(negedge clk);

    // R6 R7: remote node slower and faster than local bit
    setCfg(1, 5, 3, 1);
    doReset();
    sendFrame(50, 23);
    sendFrame(50, 21);
    setCfg(3, 15, 7, 3);
    doReset();
    sendFrame(30, 105);
    sendFrame(30, 95);

    // R8: dense noise, idle toggling, minimal segments
    setCfg(0, 2, 0, 3);
    doReset();
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if ($urandom_range(0, 9) < 3) rx = ~rx;
      if ($urandom_range(0, 99) == 0) idle = ~idle;
    end
    setCfg(1, 0, 0, 0);
    doReset();
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if ($urandom_range(0, 9) < 2) rx = ~rx;
      idle = (n < 200);
    end

    // stimulus reached each synchronization case
    check(covLong > 0, "R6", "lengthen events", covLong, 1);
    check(covShort > 0, "R7", "shorten events", covShort, 1);
    check(covCutStart > 0, "R7", "early edge starts bit", covCutStart, 1);
    check(covIgnored > 0, "R8", "locked edges", covIgnored, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule